// File: doc/BRIEF.md
# Dual-Path Fetch Buffer

This block sits between instruction fetch and rename in a wide out-of-order front end. It holds two eight-entry instruction queues. One queue holds the predicted path. The other holds the recovery path, which is fetched down the not-taken direction of a single outstanding conditional branch. Recovery fetch uses only the cycles in which the predicted queue is too full to take a whole packet. A select register decides which queue feeds rename. The other queue is never visible at the output.

When the pending branch resolves as mispredicted, the select flips in that same cycle and the old predicted queue is flushed. From the next cycle, rename draws from the queue that was collecting recovery instructions, so no refetch is needed. When the branch resolves as correctly predicted, the recovery queue is flushed and becomes free for the next branch. Only one branch is tracked at a time. While a branch is pending, the block reports that recovery capture is busy.

Top module: `dual_path_fetch_buf`

## Requirements
- R1: After reset both queues are empty, queue A (`pred_sel_o` = 0) is the predicted queue, no branch is pending (`alt_busy_o` = 0) and `out_valid_o` = 0.
- R2: A packet tagged `fetch_path_i` = 0 (predicted) is accepted (`fetch_accept_o` = 1) exactly when `fetch_valid_i` is high, no pending branch resolves in that cycle, and the predicted queue has at least `fetch_cnt_i` free entries. Its lanes (lane 0 = bits 31:0, oldest) are appended to the predicted queue in lane order.
- R3: A packet tagged `fetch_path_i` = 1 (alternate) is accepted only when a branch is pending, the predicted queue has fewer than PKT_MAX free entries, the alternate queue has room for the whole packet, and no resolve happens in that cycle. Otherwise it is rejected and nothing is stored.
- R4: Instructions in the alternate queue never reach `out_data_o` while that queue is not selected.
- R5: `out_cnt_o` equals min(predicted queue occupancy, OUT_W), and `out_valid_o` = (`out_cnt_o` != 0). Lanes below `out_cnt_o` carry the oldest entries in program order, and lanes at or above it read zero. When `out_valid_o` and `out_ready_i` are both high, `out_cnt_o` entries are removed.
- R6: In a cycle where a pending branch resolves with `br_mispredict_i` = 1, `out_valid_o` = 0 and no packet is accepted. On the next cycle `pred_sel_o` is inverted, the old predicted queue is empty, and the output draws from the former alternate queue.
- R7: A pending branch that resolves with `br_mispredict_i` = 0 empties the alternate queue, leaves `pred_sel_o` unchanged and clears the pending state.
- R8: `br_seen_i` while no branch is pending sets the pending state (`alt_busy_o` = 1 from the next cycle). `br_seen_i` while a branch is pending is ignored. `br_resolve_i` while no branch is pending is ignored.
- R9: A mispredict that arrives while the alternate queue is empty leaves the output stalled (`out_valid_o` = 0) until predicted-tagged packets fill the newly selected queue. No instruction from the flushed queue is emitted.
- R10: `pred_sel_o` = 0 means queue A is the predicted queue and 1 means queue B. Fetch tags are always relative to the current selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | Fetch packet present |
| fetch_path_i | input | 1 | 0 = predicted path, 1 = alternate path |
| fetch_cnt_i | input | 4 | Instructions in packet, 1..PKT_MAX |
| fetch_data_i | input | PKT_MAX*32 | Packet lanes, lane 0 oldest at bits 31:0 |
| fetch_accept_o | output | 1 | Packet taken this cycle |
| br_seen_i | input | 1 | Conditional branch entered on the predicted path |
| br_resolve_i | input | 1 | Pending branch resolves |
| br_mispredict_i | input | 1 | Resolve outcome was a mispredict |
| alt_busy_o | output | 1 | A branch is pending; recovery capture in use |
| pred_sel_o | output | 1 | Which queue is the predicted queue |
| out_valid_o | output | 1 | Output carries instructions |
| out_ready_i | input | 1 | Rename takes the output this cycle |
| out_cnt_o | output | 3 | Instructions on output, 0..OUT_W |
| out_data_o | output | OUT_W*32 | Output lanes, lane 0 oldest |

## Verification
The bench goes after the flip cycle itself. A design that let the old predicted head through while resolving a mispredict would hand rename one packet of wrong-path work, and a design that still accepted fetch in that cycle would write into a queue that is being flushed. It drives alternate packets when the predicted queue still has room for a full packet and when no branch is pending. A design without that gating would either steal bandwidth from the predicted path or fill the alternate queue with instructions that belong to no branch. It also covers a mispredict with an empty recovery queue, where a broken flush would replay stale entries, and a second branch arriving while one is pending, which must not disturb the pending state.

// File: rtl/dpfb_pkg.sv
package dpfb_pkg;
  parameter int unsigned INSTR_W = 32;
  typedef logic [INSTR_W-1:0] instr_t;
  typedef enum logic {PATH_PRED = 1'b0, PATH_ALT = 1'b1} path_e;
endpackage

// File: rtl/dpfb_queue.sv
// Circular instruction queue, multi-entry push and pop, DEPTH a power of two.
module dpfb_queue #(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned PKT_MAX = 8,
  parameter int unsigned OUT_W   = 4,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned PKT_CW = $clog2(PKT_MAX + 1),
  localparam int unsigned OUT_CW = $clog2(OUT_W + 1)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              flush_i,
  input  logic                              push_i,
  input  logic [PKT_CW-1:0]                 push_cnt_i,
  input  dpfb_pkg::instr_t [PKT_MAX-1:0]    push_data_i,
  input  logic                              pop_i,
  input  logic [OUT_CW-1:0]                 pop_cnt_i,
  output logic [CNT_W-1:0]                  cnt_o,
  output dpfb_pkg::instr_t [OUT_W-1:0]      head_o
);
  dpfb_pkg::instr_t mem_q [DEPTH];
  logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign do_push = push_i && !flush_i;
  assign do_pop  = pop_i && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + PTR_W'(push_cnt_i);
      if (do_pop)  rd_ptr_q <= rd_ptr_q + PTR_W'(pop_cnt_i);
      cnt_q <= cnt_q + (do_push ? CNT_W'(push_cnt_i) : '0)
                     - (do_pop  ? CNT_W'(pop_cnt_i)  : '0);
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < PKT_MAX; i++) begin
      if (do_push && (PKT_CW'(i) < push_cnt_i))
        mem_q[wr_ptr_q + PTR_W'(i)] <= push_data_i[i];
    end
  end

  always_comb begin
    for (int j = 0; j < OUT_W; j++) head_o[j] = mem_q[rd_ptr_q + PTR_W'(j)];
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dpfb_ctrl.sv
// Path select, pending-branch tracking, fetch acceptance and flush control.
module dpfb_ctrl #(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned PKT_MAX = 8,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned PKT_CW = $clog2(PKT_MAX + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [1:0][CNT_W-1:0]      q_cnt_i,
  input  logic                       fetch_valid_i,
  input  logic                       fetch_path_i,
  input  logic [PKT_CW-1:0]          fetch_cnt_i,
  input  logic                       br_seen_i,
  input  logic                       br_resolve_i,
  input  logic                       br_mispredict_i,
  output logic                       accept_o,
  output logic [1:0]                 push_o,
  output logic [1:0]                 flush_o,
  output logic                       block_out_o,
  output logic                       sel_o,
  output logic                       pending_o,
  output logic [CNT_W-1:0]           pred_cnt_o,
  output logic [CNT_W-1:0]           alt_cnt_o
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] PKT_C   = CNT_W'(PKT_MAX);

  logic sel_q, pending_q;
  logic resolve_now, mispredict_now;
  logic [CNT_W-1:0] pred_free, alt_free, pkt_len;
  logic pred_fits, pred_blocked, alt_fits, is_alt;

  assign resolve_now    = pending_q && br_resolve_i;
  assign mispredict_now = resolve_now && br_mispredict_i;

  assign pred_cnt_o   = q_cnt_i[sel_q];
  assign alt_cnt_o    = q_cnt_i[~sel_q];
  assign pred_free    = DEPTH_C - pred_cnt_o;
  assign alt_free     = DEPTH_C - alt_cnt_o;
  assign pkt_len      = CNT_W'(fetch_cnt_i);
  assign pred_fits    = pred_free >= pkt_len;
  assign alt_fits     = alt_free >= pkt_len;
  assign pred_blocked = pred_free < PKT_C;
  assign is_alt       = (fetch_path_i == dpfb_pkg::PATH_ALT);

  // predicted path has priority; alternate only rides cycles the predicted queue cannot use
  always_comb begin
    accept_o = 1'b0;
    if (fetch_valid_i && !resolve_now) begin
      if (is_alt) accept_o = pending_q && pred_blocked && alt_fits;
      else        accept_o = pred_fits;
    end
  end

  always_comb begin
    push_o          = '0;
    push_o[sel_q]   = accept_o && !is_alt;
    push_o[~sel_q]  = accept_o && is_alt;
    flush_o         = '0;
    if (mispredict_now)   flush_o[sel_q]  = 1'b1;
    else if (resolve_now) flush_o[~sel_q] = 1'b1;
  end

  assign block_out_o = mispredict_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= 1'b0;
      pending_q <= 1'b0;
    end else begin
      if (mispredict_now) sel_q <= ~sel_q;
      if (resolve_now)    pending_q <= 1'b0;
      else if (br_seen_i) pending_q <= 1'b1;
    end
  end

  assign sel_o     = sel_q;
  assign pending_o = pending_q;
endmodule

// File: rtl/dpfb_out.sv
// Output switch: only the selected queue reaches rename.
module dpfb_out #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned OUT_W  = 4,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned OUT_CW = $clog2(OUT_W + 1)
) (
  input  logic                                  sel_i,
  input  dpfb_pkg::instr_t [1:0][OUT_W-1:0]     head_i,
  input  logic [CNT_W-1:0]                      pred_cnt_i,
  input  logic                                  block_i,
  input  logic                                  ready_i,
  output logic                                  valid_o,
  output logic [OUT_CW-1:0]                     cnt_o,
  output dpfb_pkg::instr_t [OUT_W-1:0]          data_o,
  output logic [1:0]                            pop_o
);
  logic [OUT_CW-1:0] avail;

  assign avail   = (pred_cnt_i >= CNT_W'(OUT_W)) ? OUT_CW'(OUT_W) : OUT_CW'(pred_cnt_i);
  assign cnt_o   = block_i ? '0 : avail;
  assign valid_o = (cnt_o != '0);

  always_comb begin
    for (int j = 0; j < OUT_W; j++)
      data_o[j] = (OUT_CW'(j) < cnt_o) ? head_i[sel_i][j] : '0;
  end

  always_comb begin
    pop_o         = '0;
    pop_o[sel_i]  = valid_o && ready_i;
  end
endmodule

// File: rtl/dual_path_fetch_buf.sv
module dual_path_fetch_buf #(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned PKT_MAX = 8,
  parameter int unsigned OUT_W   = 4,
  localparam int unsigned IW     = dpfb_pkg::INSTR_W,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned PKT_CW = $clog2(PKT_MAX + 1),
  localparam int unsigned OUT_CW = $clog2(OUT_W + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    fetch_valid_i,
  input  logic                    fetch_path_i,
  input  logic [PKT_CW-1:0]       fetch_cnt_i,
  input  logic [PKT_MAX*IW-1:0]   fetch_data_i,
  output logic                    fetch_accept_o,
  input  logic                    br_seen_i,
  input  logic                    br_resolve_i,
  input  logic                    br_mispredict_i,
  output logic                    alt_busy_o,
  output logic                    pred_sel_o,
  output logic                    out_valid_o,
  input  logic                    out_ready_i,
  output logic [OUT_CW-1:0]       out_cnt_o,
  output logic [OUT_W*IW-1:0]     out_data_o
);
  dpfb_pkg::instr_t [PKT_MAX-1:0]     fetch_pkt;
  dpfb_pkg::instr_t [1:0][OUT_W-1:0]  q_head;
  dpfb_pkg::instr_t [OUT_W-1:0]       out_lanes;
  logic [1:0][CNT_W-1:0]              q_cnt;
  logic [1:0]                         q_push, q_flush, q_pop;
  logic [CNT_W-1:0]                   pred_cnt, alt_cnt;
  logic                               block_out;

  assign fetch_pkt  = fetch_data_i;
  assign out_data_o = out_lanes;

  for (genvar g = 0; g < 2; g++) begin : g_q
    dpfb_queue #(.DEPTH(DEPTH), .PKT_MAX(PKT_MAX), .OUT_W(OUT_W)) u_q (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .flush_i     (q_flush[g]),
      .push_i      (q_push[g]),
      .push_cnt_i  (fetch_cnt_i),
      .push_data_i (fetch_pkt),
      .pop_i       (q_pop[g]),
      .pop_cnt_i   (out_cnt_o),
      .cnt_o       (q_cnt[g]),
      .head_o      (q_head[g])
    );
  end

  dpfb_ctrl #(.DEPTH(DEPTH), .PKT_MAX(PKT_MAX)) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .q_cnt_i         (q_cnt),
    .fetch_valid_i   (fetch_valid_i),
    .fetch_path_i    (fetch_path_i),
    .fetch_cnt_i     (fetch_cnt_i),
    .br_seen_i       (br_seen_i),
    .br_resolve_i    (br_resolve_i),
    .br_mispredict_i (br_mispredict_i),
    .accept_o        (fetch_accept_o),
    .push_o          (q_push),
    .flush_o         (q_flush),
    .block_out_o     (block_out),
    .sel_o           (pred_sel_o),
    .pending_o       (alt_busy_o),
    .pred_cnt_o      (pred_cnt),
    .alt_cnt_o       (alt_cnt)
  );

  dpfb_out #(.DEPTH(DEPTH), .OUT_W(OUT_W)) u_out (
    .sel_i      (pred_sel_o),
    .head_i     (q_head),
    .pred_cnt_i (pred_cnt),
    .block_i    (block_out),
    .ready_i    (out_ready_i),
    .valid_o    (out_valid_o),
    .cnt_o      (out_cnt_o),
    .data_o     (out_lanes),
    .pop_o      (q_pop)
  );
endmodule

// File: rtl/dpfb_checker.sv
module dpfb_checker #(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned PKT_MAX = 8,
  parameter int unsigned OUT_W   = 4,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned PKT_CW = $clog2(PKT_MAX + 1),
  localparam int unsigned OUT_CW = $clog2(OUT_W + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_path_i,
  input logic [PKT_CW-1:0] fetch_cnt_i,
  input logic              fetch_accept_o,
  input logic              br_resolve_i,
  input logic              br_mispredict_i,
  input logic              alt_busy_o,
  input logic              pred_sel_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [OUT_CW-1:0] out_cnt_o,
  input logic [CNT_W-1:0]  pred_cnt,
  input logic [CNT_W-1:0]  alt_cnt
);
  logic mis_now, hit_now;
  assign mis_now = alt_busy_o && br_resolve_i && br_mispredict_i;
  assign hit_now = alt_busy_o && br_resolve_i && !br_mispredict_i;

  AST_PRED_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_accept_o && !fetch_path_i && !(out_valid_o && out_ready_i))
    |=> (pred_cnt == $past(pred_cnt) + CNT_W'($past(fetch_cnt_i)))); // R2
  AST_ALT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_accept_o && fetch_path_i)
    |-> (alt_busy_o && ((CNT_W'(DEPTH) - pred_cnt) < CNT_W'(PKT_MAX)))); // R3
  AST_OUT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_cnt_o <= OUT_CW'(OUT_W) && CNT_W'(out_cnt_o) <= pred_cnt)); // R5
  AST_FLIP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mis_now |-> (!out_valid_o && !fetch_accept_o)); // R6
  AST_FLIP_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mis_now |=> (pred_sel_o != $past(pred_sel_o))); // R6
  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mis_now |=> $stable(pred_sel_o)); // R10
  AST_HIT_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_now |=> (alt_cnt == '0 && !alt_busy_o)); // R7
  AST_BUSY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alt_busy_o && !br_resolve_i) |=> alt_busy_o); // R8
  AST_EMPTY_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mis_now && alt_cnt == '0) |=> !out_valid_o); // R9
endmodule

bind dual_path_fetch_buf dpfb_checker #(.DEPTH(DEPTH), .PKT_MAX(PKT_MAX), .OUT_W(OUT_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .fetch_path_i    (fetch_path_i),
  .fetch_cnt_i     (fetch_cnt_i),
  .fetch_accept_o  (fetch_accept_o),
  .br_resolve_i    (br_resolve_i),
  .br_mispredict_i (br_mispredict_i),
  .alt_busy_o      (alt_busy_o),
  .pred_sel_o      (pred_sel_o),
  .out_valid_o     (out_valid_o),
  .out_ready_i     (out_ready_i),
  .out_cnt_o       (out_cnt_o),
  .pred_cnt        (pred_cnt),
  .alt_cnt         (alt_cnt)
);

// File: tb/dual_path_fetch_buf_bench.sv
module dual_path_fetch_buf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8, PKT_MAX = 8, OUT_W = 4, IW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic f_valid = 0, f_path = 0, seen = 0, res = 0, mis = 0, ready = 0;
  logic [3:0] f_cnt = 4'd1;
  logic [PKT_MAX*IW-1:0] f_data = '0;
  logic f_acc, busy, sel, o_valid;
  logic [2:0] o_cnt;
  logic [OUT_W*IW-1:0] o_data;

  int n_run = 0, n_fail = 0, cyc = 0;
  int unsigned pseq = 0, aseq = 0;
  int unsigned mq [2][$];
  bit m_sel = 0, m_pend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_path_fetch_buf u_dual_path_fetch_buf (
    .clk_i(clk), .rst_ni(rst_n), .fetch_valid_i(f_valid), .fetch_path_i(f_path),
    .fetch_cnt_i(f_cnt), .fetch_data_i(f_data), .fetch_accept_o(f_acc),
    .br_seen_i(seen), .br_resolve_i(res), .br_mispredict_i(mis),
    .alt_busy_o(busy), .pred_sel_o(sel), .out_valid_o(o_valid),
    .out_ready_i(ready), .out_cnt_o(o_cnt), .out_data_o(o_data));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(string tag, string what, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // set packet inputs with fresh tokens; alternate tokens carry 0xA in the top nibble
  task automatic set_in(bit v, bit p, int c, bit s, bit r, bit m, bit rd);
    f_valid = v; f_path = p; f_cnt = 4'(c); seen = s; res = r; mis = m; ready = rd;
    for (int i = 0; i < PKT_MAX; i++)
      f_data[i*IW +: IW] = p ? (32'hA000_0000 + aseq + i) : (32'h1000_0000 + pseq + i);
  endtask

  // compare at negedge against the model, then advance the model
  task automatic tick(string tag);
    int pc, ac, oc; bit rs, ms, acc; int tgt;
    @(negedge clk);
    pc = mq[m_sel].size(); ac = mq[!m_sel].size();
    rs = m_pend && res; ms = rs && mis;
    acc = f_valid && !rs && (f_path ? (m_pend && (DEPTH - pc) < PKT_MAX && (DEPTH - ac) >= int'(f_cnt))
                                     : ((DEPTH - pc) >= int'(f_cnt)));
    oc = ms ? 0 : (pc > OUT_W ? OUT_W : pc);
    chk({tag, f_path ? " R3" : " R2"}, "fetch_accept", f_acc, acc);
    chk({tag, ms ? " R6" : " R5"}, "out_valid", o_valid, oc != 0);
    chk({tag, " R5"}, "out_cnt", o_cnt, oc);
    for (int j = 0; j < OUT_W; j++) begin
      longint e = (j < oc) ? mq[m_sel][j] : 0;
      chk({tag, o_data[j*IW+28 +: 4] == 4'hA && e != o_data[j*IW +: IW] ? " R4" : " R5"},
          $sformatf("lane%0d", j), o_data[j*IW +: IW], e);
    end
    chk({tag, " R8"}, "alt_busy", busy, m_pend);
    chk({tag, " R10"}, "pred_sel", sel, m_sel);
    if (oc != 0 && ready) for (int k = 0; k < oc; k++) void'(mq[m_sel].pop_front());
    if (acc) begin
      tgt = f_path ? int'(!m_sel) : int'(m_sel);
      for (int i = 0; i < int'(f_cnt); i++) mq[tgt].push_back(f_data[i*IW +: IW]);
      if (f_path) aseq += PKT_MAX; else pseq += PKT_MAX;
    end
    if (ms) begin mq[m_sel].delete(); m_sel = !m_sel; end
    else if (rs) mq[!m_sel].delete();
    if (rs) m_pend = 0; else if (seen) m_pend = 1;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "out_valid", o_valid, 0);
    chk("R1", "alt_busy", busy, 0);
    chk("R10", "pred_sel", sel, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    set_in(1, 0, 6, 0, 0, 0, 0); tick("R2 fill");
    set_in(1, 1, 3, 0, 0, 0, 0); tick("R3 no-branch");
    set_in(0, 0, 1, 1, 0, 0, 0); tick("R8 seen");
    set_in(1, 1, 4, 0, 0, 0, 0); tick("R3 alt-capture");
    set_in(1, 0, 3, 0, 0, 0, 0); tick("R2 too-big");
    set_in(1, 0, 2, 1, 0, 0, 0); tick("R8 second-branch");
    set_in(0, 0, 1, 0, 0, 0, 1); tick("R5 drain4");
    set_in(0, 0, 1, 0, 1, 1, 1); tick("R6 flip");
    chk("R6", "pred_sel after flip", sel, 1);
    chk("R4", "first recovery lane", o_data[IW-1:0], 32'hA000_0000);
    set_in(0, 0, 1, 0, 0, 0, 1); tick("R6 recovery");
    set_in(0, 0, 1, 1, 0, 0, 1); tick("R8 seen2");
    set_in(1, 1, 5, 0, 0, 0, 0); tick("R3 pred-room");
    set_in(1, 0, 8, 0, 0, 0, 0); tick("R2 full");
    set_in(1, 1, 5, 0, 0, 0, 0); tick("R3 alt-ok");
    set_in(0, 0, 1, 0, 1, 0, 0); tick("R7 hit");
    chk("R7", "alt_busy after hit", busy, 0);
    set_in(1, 1, 2, 0, 0, 0, 0); tick("R7 alt-after-hit");
    set_in(0, 0, 1, 1, 0, 0, 1); tick("R9 arm");
    set_in(0, 0, 1, 0, 1, 1, 1); tick("R9 flip-empty");
    for (int i = 0; i < 3; i++) begin
      set_in(0, 0, 1, 0, 0, 0, 1); tick("R9 stall");
      chk("R9", "out_valid stalled", o_valid, 0);
    end
    set_in(1, 0, 2, 0, 0, 0, 1); tick("R9 refill");
    chk("R9", "out_cnt after refill", o_cnt, 2);

    for (int i = 0; i < 6000; i++) begin
      bit r = ($urandom_range(0, 19) == 0);
      set_in($urandom_range(0, 9) < 7, $urandom_range(0, 9) < 4, $urandom_range(1, PKT_MAX),
             $urandom_range(0, 9) == 0, r, $urandom_range(0, 1), $urandom_range(0, 2) != 0);
      tick("rand");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule